// File: doc/BRIEF.md
# Programmable Serial Frame Transmitter

This block turns bytes written into a small buffer into asynchronous serial frames on a single output line. It is paced by a tick that pulses sixteen times per bit period. Each frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames.

Software or a neighbouring block sets the frame format with a handful of static controls. It pushes characters through a one-cycle write strobe and watches the full, empty and busy flags to pace itself. A break control can hold the line low for as long as needed. The buffer is either a sixteen-entry queue or a single holding register, chosen by a mode input. Nothing is sent unless both the global enable and the transmit enable are high. If either drops in the middle of a frame, the frame pauses and later resumes where it stopped.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: A frame begins with a low start bit, followed by the data bits least significant bit first. Every bit lasts 16 `tick16` pulses. `len_code` sets the data bit count: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8.
- R3: With `par_en`=1 and `par_stick`=0, one parity bit follows the data bits. It is the XOR of the sent data bits when `par_even`=1, and the inverse of that XOR when `par_even`=0.
- R4: With `par_en`=1 and `par_stick`=1, the parity bit is 0 when `par_even`=1 and 1 when `par_even`=0, whatever the data.
- R5: The frame ends with one stop bit (`two_stop`=0) or two stop bits (`two_stop`=1). Stop bits are high.
- R6: When `brk`=1, `txd` is low whenever no frame is in progress. A frame already running completes unchanged. No new frame starts until `brk` returns to 0.
- R7: With `fifo_en`=1 the buffer holds 16 characters and sends them in write order. `fifo_full` rises after 16 unsent writes. A write while `fifo_full`=1 is dropped.
- R8: With `fifo_en`=0 the buffer holds a single character. `fifo_full` is 1 once it is occupied, and a second write is dropped.
- R9: A frame starts only while `uart_en`=1 and `tx_en`=1. If either is 0 during a frame, `txd` and the bit timing freeze until both are 1 again.
- R10: `busy` is 1 from the start bit through the end of the last stop bit, and is 0 otherwise.
- R11: The format controls are captured when a frame starts. Changing them during the frame does not alter that frame.
- R12: A write in the same cycle as the serializer takes a character from the queue is kept, and both characters are sent in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to send (upper bits unused for short lengths) |
| len_code | input | 2 | Data length code |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity / stick value select |
| par_stick | input | 1 | Constant parity bit |
| two_stop | input | 1 | Two stop bits |
| brk | input | 1 | Force line low when idle |
| fifo_en | input | 1 | 16-entry queue (1) or single holding register (0) |
| uart_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| txd | output | 1 | Serial output |
| fifo_full | output | 1 | Buffer full |
| fifo_empty | output | 1 | Buffer empty |
| busy | output | 1 | Frame in progress |

## Verification
Two functions can fall in the same cycle: a write into the queue, and the serializer taking the head character to start a frame. The bench writes one byte into an idle transmitter and writes a second byte on exactly the next cycle, which is the cycle of the load. Directly after that, the bench requires `fifo_empty`=0 and `busy`=1. It then decodes both frames and requires the two bytes to appear in write order. A second case that stresses the frame boundary is a break request raised in the middle of a frame. That frame must decode intact, and only afterwards may the line go low.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       two_stop;
  } frame_fmt_t;

  // data bit count is 5 plus the length code
  function automatic logic [3:0] len_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/uft_rst_sync.sv
module uft_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/uft_fifo.sv
module uft_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deep_mode,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d, cap;
  logic          push_ok, pop_ok;

  assign cap     = deep_mode ? CW'(DEPTH) : CW'(1);
  assign full    = (cnt_q >= cap);
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem_q[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop_ok)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wptr_q] <= din;
  end
endmodule

// File: rtl/uft_bit_timer.sv
module uft_bit_timer #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign bit_end = run && tick && (cnt_q == CW'(OSR - 1));
  assign cnt_en  = clear || (run && tick);

  always_comb begin
    if (clear || bit_end) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uft_parity.sv
module uft_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]     data,
  input  uft_pkg::frame_fmt_t fmt,
  output logic              par_bit
);
  logic [DW-1:0] masked;
  logic [3:0]    nbits;

  assign nbits = uft_pkg::len_bits(fmt.len);

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign masked[i] = data[i] && (4'(i) < nbits);
  end

  always_comb begin
    if (fmt.par_stick)     par_bit = !fmt.par_even;
    else if (fmt.par_even) par_bit = ^masked;
    else                   par_bit = ~(^masked);
  end
endmodule

// File: rtl/uft_serializer.sv
module uft_serializer #(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_en,
  input  logic                brk,
  input  logic                avail,
  input  logic [DW-1:0]       char_in,
  input  uft_pkg::frame_fmt_t fmt_in,
  input  logic                par_in,
  input  logic                bit_end,
  output logic                load,
  output logic                active,
  output logic                txd
);
  import uft_pkg::*;

  localparam int IW = (DW > 1) ? $clog2(DW) : 1;

  tx_state_e  state_q, state_d;
  logic [DW-1:0] shreg_q, shreg_d;
  logic [IW-1:0] idx_q, idx_d;
  frame_fmt_t fmt_q, fmt_d;
  logic       par_q, par_d;
  logic       stop2_q, stop2_d;
  logic       reg_en;
  logic [3:0] nbits;

  assign load   = (state_q == ST_IDLE) && go_en && avail && !brk;
  assign active = (state_q != ST_IDLE);
  assign nbits  = len_bits(fmt_q.len);
  assign reg_en = load || bit_end;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    idx_d   = idx_q;
    fmt_d   = fmt_q;
    par_d   = par_q;
    stop2_d = stop2_q;
    if (load) begin
      state_d = ST_START;
      shreg_d = char_in;
      fmt_d   = fmt_in;
      par_d   = par_in;
      idx_d   = '0;
      stop2_d = 1'b0;
    end else if (bit_end) begin
      case (state_q)
        ST_START: state_d = ST_DATA;
        ST_DATA: begin
          shreg_d = shreg_q >> 1;
          if ({1'b0, idx_q} == IW'(nbits - 4'd1)) begin
            state_d = fmt_q.par_en ? ST_PAR : ST_STOP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_PAR:  state_d = ST_STOP;
        ST_STOP: begin
          if (fmt_q.two_stop && !stop2_q) stop2_d = 1'b1;
          else                            state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      fmt_q   <= '0;
      par_q   <= 1'b0;
      stop2_q <= 1'b0;
    end else if (reg_en) begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
      fmt_q   <= fmt_d;
      par_q   <= par_d;
      stop2_q <= stop2_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg_q[0];
      ST_PAR:   txd = par_q;
      ST_STOP:  txd = 1'b1;
      default:  txd = !brk;
    endcase
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    len_code,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          par_stick,
  input  logic          two_stop,
  input  logic          brk,
  input  logic          fifo_en,
  input  logic          uart_en,
  input  logic          tx_en,
  output logic          txd,
  output logic          fifo_full,
  output logic          fifo_empty,
  output logic          busy
);
  import uft_pkg::*;

  logic          rst_i_n;
  logic          go_en, load, bit_end, par_bit;
  logic [DW-1:0] head;
  frame_fmt_t    fmt_live;

  assign go_en    = uart_en && tx_en;
  assign fmt_live = '{len: len_code, par_en: par_en, par_even: par_even,
                      par_stick: par_stick, two_stop: two_stop};

  uft_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  uft_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .deep_mode (fifo_en),
    .push      (wr_en),
    .din       (wr_data),
    .pop       (load),
    .dout      (head),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  uft_parity #(.DW(DW)) i_parity (
    .data    (head),
    .fmt     (fmt_live),
    .par_bit (par_bit)
  );

  uft_bit_timer #(.OSR(OSR)) i_timer (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clear   (load),
    .run     (busy && go_en),
    .tick    (tick16),
    .bit_end (bit_end)
  );

  uft_serializer #(.DW(DW)) i_ser (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .go_en   (go_en),
    .brk     (brk),
    .avail   (!fifo_empty),
    .char_in (head),
    .fmt_in  (fmt_live),
    .par_in  (par_bit),
    .bit_end (bit_end),
    .load    (load),
    .active  (busy),
    .txd     (txd)
  );
endmodule

// File: rtl/uft_checker.sv
module uft_checker (
  input logic clk,
  input logic rst_n,
  input logic brk,
  input logic uart_en,
  input logic tx_en,
  input logic txd,
  input logic fifo_full,
  input logic fifo_empty,
  input logic busy
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> txd); // R1

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R2

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && brk) |-> !txd); // R6

  AST_BREAK_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && brk) |=> !busy); // R6

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty)); // R7

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(uart_en && tx_en)) |=> ($stable(txd) && busy)); // R9

  AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !busy) |=> !busy); // R10
endmodule

bind uart_frame_tx uft_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .brk        (brk),
  .uart_en    (uart_en),
  .tx_en      (tx_en),
  .txd        (txd),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .busy       (busy)
);

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/1ps
module test_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n, tick16, wr_en;
  logic [7:0] wr_data;
  logic [1:0] len_code;
  logic       par_en, par_even, par_stick, two_stop, brk, fifo_en, uart_en, tx_en;
  logic       txd, fifo_full, fifo_empty, busy;
  int         n_tests = 0;
  int         n_fail  = 0;

  always #2 clk = ~clk;

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .len_code(len_code), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .two_stop(two_stop), .brk(brk), .fifo_en(fifo_en), .uart_en(uart_en), .tx_en(tx_en),
    .txd(txd), .fifo_full(fifo_full), .fifo_empty(fifo_empty), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_char(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // expected line bits, index 0 = start bit
  task automatic build_frame(input logic [7:0] d, output logic [11:0] bits, output int nb);
    int n = 5 + int'(len_code);
    logic x = 1'b0;
    bits = '1; bits[0] = 1'b0; nb = 1;
    for (int i = 0; i < n; i++) begin bits[nb] = d[i]; x ^= d[i]; nb++; end
    if (par_en) begin
      bits[nb] = par_stick ? !par_even : (par_even ? x : !x);
      nb++;
    end
    bits[nb] = 1'b1; nb++;
    if (two_stop) begin bits[nb] = 1'b1; nb++; end
  endtask

  // sample mid-bit; returns bits and busy at the middle of the last stop bit
  task automatic capture(input int nb, output logic [11:0] bits, output logic last_busy,
                         output logic ok);
    int w = 0;
    bits = '1; ok = 1'b1; last_busy = 1'b0;
    while (txd !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
    if (w >= 3000) ok = 1'b0;
    repeat (7) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      bits[i] = txd;
      if (i == nb - 1) last_busy = busy;
      else repeat (16) @(negedge clk);
    end
  endtask

  task automatic frame_check(input string req, input logic [7:0] d);
    logic [11:0] e, a;
    int nb;
    logic lb, ok;
    build_frame(d, e, nb);
    capture(nb, a, lb, ok);
    check({req, " frame start seen"}, 32'(ok), 32'd1);
    check({req, " frame bits"}, 32'(a), 32'(e));
    check("R10 busy in last stop bit", 32'(lb), 32'd1);
  endtask

  task automatic wait_idle_check(input string req);
    repeat (10) @(negedge clk);
    check({req, " busy low after frame"}, 32'(busy), 32'd0);
    check({req, " line high after frame"}, 32'(txd), 32'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 txd after reset", 32'(txd), 32'd1);
    check("R1 busy after reset", 32'(busy), 32'd0);
    check("R1 empty after reset", 32'(fifo_empty), 32'd1);
    check("R1 full after reset", 32'(fifo_full), 32'd0);
  endtask

  task automatic t_lengths;
    logic [7:0] pat [4] = '{8'hA5, 8'h3C, 8'h5B, 8'hC9};
    par_en = 1'b0; two_stop = 1'b0;
    for (int c = 0; c < 4; c++) begin
      len_code = 2'(c);
      write_char(pat[c]);
      frame_check("R2", pat[c]);
      wait_idle_check("R10");
    end
  endtask

  task automatic t_parity;
    par_en = 1'b1; par_stick = 1'b0;
    len_code = 2'b11; par_even = 1'b1; write_char(8'h13); frame_check("R3 even 8b", 8'h13);
    wait_idle_check("R3");
    par_even = 1'b0; write_char(8'h13); frame_check("R3 odd 8b", 8'h13);
    wait_idle_check("R3");
    len_code = 2'b10; par_even = 1'b1; write_char(8'hC1); frame_check("R3 even 7b", 8'hC1);
    wait_idle_check("R3");
    par_en = 1'b0;
  endtask

  task automatic t_stick;
    par_en = 1'b1; par_stick = 1'b1; len_code = 2'b11;
    par_even = 1'b1; write_char(8'h01); frame_check("R4 stick zero", 8'h01);
    wait_idle_check("R4");
    par_even = 1'b0; write_char(8'h03); frame_check("R4 stick one", 8'h03);
    wait_idle_check("R4");
    par_en = 1'b0; par_stick = 1'b0;
  endtask

  task automatic t_stop;
    two_stop = 1'b1; len_code = 2'b01;
    write_char(8'h2A); frame_check("R5 two stop", 8'h2A);
    wait_idle_check("R5");
    two_stop = 1'b0;
  endtask

  task automatic t_break;
    len_code = 2'b11;
    write_char(8'h96);
    fork
      frame_check("R6 frame runs to end under break", 8'h96);
      begin repeat (50) @(negedge clk); brk = 1'b1; end
    join
    repeat (10) @(negedge clk);
    check("R6 line low in break", 32'(txd), 32'd0);
    write_char(8'h55);
    repeat (40) @(negedge clk);
    check("R6 no start during break", 32'(busy), 32'd0);
    check("R6 char still queued", 32'(fifo_empty), 32'd0);
    check("R6 line still low", 32'(txd), 32'd0);
    brk = 1'b0;
    frame_check("R6 queued char after release", 8'h55);
    wait_idle_check("R6");
  endtask

  task automatic t_fifo_deep;
    fifo_en = 1'b1; tx_en = 1'b0; len_code = 2'b11;
    for (int i = 0; i < 16; i++) write_char(8'(8'h40 + i));
    check("R7 full after 16 writes", 32'(fifo_full), 32'd1);
    write_char(8'hEE);
    check("R7 still full after dropped write", 32'(fifo_full), 32'd1);
    tx_en = 1'b1;
    for (int i = 0; i < 16; i++) frame_check("R7 queue order", 8'(8'h40 + i));
    repeat (200) @(negedge clk);
    check("R7 dropped write never sent", 32'(busy), 32'd0);
    check("R7 empty after drain", 32'(fifo_empty), 32'd1);
  endtask

  task automatic t_fifo_single;
    fifo_en = 1'b0; tx_en = 1'b0;
    write_char(8'h61);
    check("R8 full with one char", 32'(fifo_full), 32'd1);
    write_char(8'h62);
    tx_en = 1'b1;
    frame_check("R8 held char", 8'h61);
    repeat (200) @(negedge clk);
    check("R8 second write dropped", 32'(busy), 32'd0);
    check("R8 empty", 32'(fifo_empty), 32'd1);
    fifo_en = 1'b1;
  endtask

  task automatic t_enable;
    bit stuck, rose;
    int w;
    tx_en = 1'b0; len_code = 2'b11;
    write_char(8'h01);
    repeat (30) @(negedge clk);
    check("R9 no start with tx_en low", 32'(busy), 32'd0);
    uart_en = 1'b0; tx_en = 1'b1;
    repeat (30) @(negedge clk);
    check("R9 no start with uart_en low", 32'(busy), 32'd0);
    uart_en = 1'b1;
    w = 0;
    while (txd !== 1'b0 && w < 100) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    tx_en = 1'b0;
    stuck = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (txd !== 1'b0 || busy !== 1'b1) stuck = 1'b0;
    end
    check("R9 frame frozen while disabled", 32'(stuck), 32'd1);
    tx_en = 1'b1;
    rose = 1'b0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); if (txd === 1'b1) rose = 1'b1; end
    check("R9 resumes to data bit 0", 32'(rose), 32'd1);
    repeat (160) @(negedge clk);
    check("R9 frame completes after resume", 32'(busy), 32'd0);
  endtask

  task automatic t_latch;
    len_code = 2'b11; par_en = 1'b0; two_stop = 1'b0;
    write_char(8'hB4);
    fork
      frame_check("R11 format latched at start", 8'hB4);
      begin
        repeat (40) @(negedge clk);
        len_code = 2'b00; par_en = 1'b1; two_stop = 1'b1;
      end
    join
    wait_idle_check("R11");
    len_code = 2'b11; par_en = 1'b0; two_stop = 1'b0;
  endtask

  task automatic t_push_pop;
    fifo_en = 1'b1; len_code = 2'b11;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hD2;
    @(negedge clk); wr_data = 8'h2D;
    @(negedge clk); wr_en = 1'b0;
    check("R12 busy after load", 32'(busy), 32'd1);
    check("R12 second char kept", 32'(fifo_empty), 32'd0);
    frame_check("R12 first char", 8'hD2);
    frame_check("R12 second char", 8'h2D);
    wait_idle_check("R12");
    check("R12 empty after both", 32'(fifo_empty), 32'd1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick16 = 1'b1; wr_en = 1'b0; wr_data = '0;
    len_code = 2'b11; par_en = 1'b0; par_even = 1'b0; par_stick = 1'b0;
    two_stop = 1'b0; brk = 1'b0; fifo_en = 1'b1; uart_en = 1'b1; tx_en = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lengths();
    t_parity();
    t_stick();
    t_stop();
    t_break();
    t_fifo_deep();
    t_fifo_single();
    t_enable();
    t_latch();
    t_push_pop();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule